// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a 128-bit vector operand by its own signed amount. The amount comes from the matching lane of a second operand. Two control inputs set the lane size (8 or 16 bits) and say whether lanes are signed or unsigned. A non-negative amount shifts the lane left. A negative amount shifts it right. Amounts outside the lane width give fixed results: zero in most cases, and sign fill for a signed right shift.

An active-size input gives the number of live bytes, counted from byte 0. Every result byte at or above that count is forced to zero. The block takes its operands on any cycle where `in_valid` is high. The masked result appears one clock later, together with `out_valid`. Every lane is computed in parallel, and no lane depends on its neighbours.

Top module: `vshift_unit`

## Requirements
- R1: Lane i sits at bits [W*i +: W] of each operand, where W is 8 when `lane_wide`=0 and 16 when `lane_wide`=1. Each lane's result depends only on that lane's inputs.
- R2: The shift amount of a lane is the low byte of that lane of `opnd_m`, read as a two's-complement value from -128 to 127. For 16-bit lanes, the upper byte of the `opnd_m` lane has no effect on the result.
- R3: An amount from 0 to W-1 shifts the `opnd_n` lane left by that amount and fills with zeros.
- R4: An amount of W or more gives a zero lane.
- R5: When `is_signed`=1, a negative amount -k with k < W is an arithmetic right shift by k.
- R6: When `is_signed`=1, a negative amount -k with k >= W fills the whole lane with copies of the lane's top bit.
- R7: When `is_signed`=0, a negative amount -k with k < W is a logical right shift by k. With k >= W the lane is zero.
- R8: Every result byte whose index is equal to or greater than `act_bytes` is zero. Valid values of `act_bytes` are multiples of the lane size in bytes, up to 16.
- R9: `out_valid` equals `in_valid` from the previous cycle. The result register loads only on a cycle where `in_valid` is high, and it keeps its value otherwise.
- R10: A synchronous reset clears `out_valid` and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_wide | input | 1 | 0 selects 8-bit lanes, 1 selects 16-bit lanes |
| is_signed | input | 1 | 1 selects signed lanes (arithmetic right shift) |
| act_bytes | input | 5 | Number of live bytes, counted from byte 0 |
| opnd_n | input | 128 | Data vector to be shifted |
| opnd_m | input | 128 | Vector of per-lane shift amounts |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Registered, masked result vector |

## Verification
The hardest cases to reach from the ports are the boundaries of the count decode. These are an amount of exactly -W or +W, and -128, whose magnitude does not fit in a signed byte. For 16-bit lanes there is also an upper `opnd_m` byte that carries nonzero junk. Directed tasks place these exact amounts next to ordinary amounts in neighbouring lanes, so one vector covers several regions of the decode and also shows that lanes do not interact. Each directed task drives the signed and unsigned modes with the same operands. A mixed run then pairs random operands with random legal active sizes, and each result is checked against a model built from the requirements.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    localparam int VEC_BYTES = 16;
    localparam int BYTE_W    = 8;
    localparam int VEC_BITS  = VEC_BYTES * BYTE_W;
    localparam int ACT_W     = $clog2(VEC_BYTES) + 1;
    localparam int AMT_W     = 8;

    typedef struct packed {
        logic                vld;
        logic [VEC_BITS-1:0] data;
    } vshift_state_t;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
    parameter int W     = 8,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     lane_in,
    input  logic [AMT_W-1:0] amt,
    input  logic             arith,
    output logic [W-1:0]     lane_out
);
    localparam int SH_W  = $clog2(W);
    localparam int MAG_W = AMT_W + 1;

    logic [MAG_W-1:0] mag;
    logic             neg;
    logic             left_ok;
    logic             right_ok;

    always_comb begin
        neg      = amt[AMT_W-1];
        // magnitude of a negative count; -128 becomes 128, which needs MAG_W bits
        mag      = MAG_W'(1 << AMT_W) - {1'b0, amt};
        left_ok  = ({1'b0, amt} < MAG_W'(W));
        right_ok = (mag < MAG_W'(W));
        if (!neg) begin
            lane_out = left_ok ? (lane_in << amt[SH_W-1:0]) : '0;
        end else if (right_ok) begin
            if (arith) lane_out = W'($signed(lane_in) >>> mag[SH_W-1:0]);
            else       lane_out = lane_in >> mag[SH_W-1:0];
        end else begin
            lane_out = arith ? {W{lane_in[W-1]}} : '0;
        end
    end
endmodule

// File: rtl/vshift_tail_mask.sv
module vshift_tail_mask #(
    parameter int VEC_BYTES = 16,
    parameter int ACT_W     = 5
) (
    input  logic [ACT_W-1:0]       act_bytes,
    output logic [VEC_BYTES*8-1:0] keep_bits
);
    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
        assign keep_bits[b*8 +: 8] = {8{ACT_W'(b) < act_bytes}};
    end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                lane_wide,
    input  logic                is_signed,
    input  logic [ACT_W-1:0]    act_bytes,
    input  logic [VEC_BITS-1:0] opnd_n,
    input  logic [VEC_BITS-1:0] opnd_m,
    output logic                out_valid,
    output logic [VEC_BITS-1:0] result
);
    localparam int HALF_W     = 2 * BYTE_W;
    localparam int HALF_LANES = VEC_BYTES / 2;

    logic [VEC_BITS-1:0] byte_res;
    logic [VEC_BITS-1:0] half_res;
    logic [VEC_BITS-1:0] keep_bits;
    vshift_state_t       st_d, st_q;

    for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte_lane
        vshift_lane #(.W(BYTE_W), .AMT_W(AMT_W)) u_lane (
            .lane_in  (opnd_n[i*BYTE_W +: BYTE_W]),
            .amt      (opnd_m[i*BYTE_W +: AMT_W]),
            .arith    (is_signed),
            .lane_out (byte_res[i*BYTE_W +: BYTE_W])
        );
    end

    for (genvar i = 0; i < HALF_LANES; i++) begin : g_half_lane
        vshift_lane #(.W(HALF_W), .AMT_W(AMT_W)) u_lane (
            .lane_in  (opnd_n[i*HALF_W +: HALF_W]),
            .amt      (opnd_m[i*HALF_W +: AMT_W]),
            .arith    (is_signed),
            .lane_out (half_res[i*HALF_W +: HALF_W])
        );
    end

    vshift_tail_mask #(.VEC_BYTES(VEC_BYTES), .ACT_W(ACT_W)) u_mask (
        .act_bytes (act_bytes),
        .keep_bits (keep_bits)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = (lane_wide ? half_res : byte_res) & keep_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.data;

    // R9: valid tracks the input one cycle later
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: result held while idle
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R8: no live data above the active size
    a_r8_tail_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((result >> ({3'b0, $past(act_bytes)} * 8)) == '0));
    // R4: over-range left count on byte lane 0
    a_r4_left_over: assert property (@(posedge clk) disable iff (rst)
        (!opnd_m[7] && opnd_m[7:0] >= 8'd8) |-> byte_res[7:0] == 8'h00);
    // R6: signed far right on byte lane 0 gives sign fill
    a_r6_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (is_signed && opnd_m[7] && opnd_m[7:0] <= 8'hF8) |-> byte_res[7:0] == {8{opnd_n[7]}});
    // R7: unsigned far right on half lane 0 gives zero
    a_r7_unsigned_over: assert property (@(posedge clk) disable iff (rst)
        (!is_signed && opnd_m[7] && opnd_m[7:0] <= 8'hF0) |-> half_res[15:0] == 16'h0000);
endmodule

// File: tb/tb_vshift_unit.sv
module tb_vshift_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         lane_wide;
    logic         is_signed;
    logic [4:0]   act_bytes;
    logic [127:0] opnd_n;
    logic [127:0] opnd_m;
    logic         out_valid;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    vshift_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_wide(lane_wide),
        .is_signed(is_signed), .act_bytes(act_bytes), .opnd_n(opnd_n),
        .opnd_m(opnd_m), .out_valid(out_valid), .result(result)
    );

    function automatic logic [15:0] ref_lane(logic [15:0] v, logic [7:0] a, bit wide, bit sg);
        int w = wide ? 16 : 8;
        int c = int'($signed(a));
        logic [31:0] u  = wide ? {16'h0, v} : {24'h0, v[7:0]};
        logic signed [31:0] s = wide ? {{16{v[15]}}, v} : {{24{v[7]}}, v[7:0]};
        logic [31:0] r;
        int k;
        if (c >= 0) r = (c < w) ? (u << c) : 32'h0;
        else begin
            k = -c;
            if (sg) begin
                if (k >= w) k = w - 1;
                r = 32'(s >>> k);
            end else r = (k < w) ? (u >> k) : 32'h0;
        end
        return wide ? r[15:0] : {8'h0, r[7:0]};
    endfunction

    function automatic logic [127:0] ref_vec(logic [127:0] n, logic [127:0] m, bit wide, bit sg, int act);
        logic [127:0] o = '0;
        logic [15:0]  t;
        if (wide) begin
            for (int i = 0; i < 8; i++) begin
                t = ref_lane(n[16*i +: 16], m[16*i +: 8], 1'b1, sg);
                o[16*i +: 16] = t;
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                t = ref_lane({8'h0, n[8*i +: 8]}, m[8*i +: 8], 1'b0, sg);
                o[8*i +: 8] = t[7:0];
            end
        end
        for (int b = 0; b < 16; b++) if (b >= act) o[8*b +: 8] = 8'h0;
        return o;
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act_v, logic [127:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic run(logic [127:0] n, logic [127:0] m, bit wide, bit sg, int act, string tag);
        logic [127:0] e;
        @(negedge clk);
        in_valid = 1; lane_wide = wide; is_signed = sg; act_bytes = 5'(act);
        opnd_n = n; opnd_m = m;
        @(negedge clk);
        in_valid = 0;
        e = ref_vec(n, m, wide, sg, act);
        check(result == e, tag, result, e);
        check(out_valid == 1'b1, {tag, " R9 valid"}, 128'(out_valid), 128'h1);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check(out_valid == 1'b0, "R10 valid", 128'(out_valid), 128'h0);
        check(result == '0, "R10 result", result, '0);
    endtask

    task automatic t_byte_left;
        // lanes: amt 0,3,7,8,127,1 ...
        run({16{8'h81}}, {80'h0, 8'h01, 8'h7F, 8'h08, 8'h07, 8'h03, 8'h00}, 0, 0, 16, "R3 R4 byte left");
        check(result[47:0] == 48'h02_00_00_80_08_81, "R3 R4 byte literal", 128'(result[47:0]), 128'h020000800881);
        run({16{8'h81}}, {80'h0, 8'h01, 8'h7F, 8'h08, 8'h07, 8'h03, 8'h00}, 0, 1, 16, "R3 R4 byte left signed");
    endtask

    task automatic t_byte_right;
        // amts -2, -7, -8, -128 with data 0x90
        run({16{8'h90}}, {96'h0, 8'h80, 8'hF8, 8'hF9, 8'hFE}, 0, 1, 16, "R5 R6 byte signed right");
        check(result[31:0] == 32'hFF_FF_FF_E4, "R6 byte sign fill", 128'(result[31:0]), 128'hFFFFFFE4);
        run({16{8'h90}}, {96'h0, 8'h80, 8'hF8, 8'hF9, 8'hFE}, 0, 0, 16, "R7 byte unsigned right");
        check(result[31:0] == 32'h00_00_01_24, "R7 byte literal", 128'(result[31:0]), 128'h124);
        run({16{8'h70}}, {96'h0, 8'h80, 8'hF8, 8'hF9, 8'hFE}, 0, 1, 16, "R6 positive sign fill");
    endtask

    task automatic t_half;
        // lane0 amt 1 with junk upper byte; lane1 -16; lane2 -15; lane3 16; lane4 15
        logic [127:0] m = {48'h0, 16'h550F, 16'hFF10, 16'h12F1, 16'h00F0, 16'hAB01};
        run({8{16'h8001}}, m, 1, 1, 16, "R1 R2 half signed");
        check(result[47:0] == 48'hFFFF_FFFF_0002, "R2 R6 half literal", 128'(result[47:0]), 128'hFFFFFFFF0002);
        run({8{16'h8001}}, m, 1, 0, 16, "R1 R7 half unsigned");
        check(result[47:0] == 48'h0001_0000_0002, "R7 half literal", 128'(result[47:0]), 128'h000100000002);
        run({8{16'h8001}}, {m[127:16], 16'h0001}, 1, 0, 16, "R2 upper byte ignored");
    endtask

    task automatic t_tail;
        run({16{8'hA5}}, '0, 0, 0, 5, "R8 byte act 5");
        check(result[127:40] == '0, "R8 tail literal", result, 128'h0);
        run({8{16'h1234}}, {8{16'h0001}}, 1, 1, 2, "R8 half act 2");
        run({8{16'h1234}}, '0, 1, 0, 0, "R8 act 0");
        run({16{8'h3C}}, {16{8'h01}}, 0, 1, 15, "R8 byte act 15");
    endtask

    task automatic t_hold;
        logic [127:0] keep;
        run({16{8'h11}}, '0, 0, 0, 16, "R9 load");
        keep = result;
        @(negedge clk); opnd_n = '1; opnd_m = '0; act_bytes = 16;
        @(negedge clk);
        check(result == keep, "R9 hold result", result, keep);
        check(out_valid == 1'b0, "R9 idle valid", 128'(out_valid), 128'h0);
    endtask

    task automatic t_mixed;
        for (int k = 0; k < 200; k++) begin
            bit wide = k[0];
            bit sg = k[1];
            int act = wide ? 2 * (1 + ($urandom % 8)) : 1 + ($urandom % 16);
            logic [127:0] n = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] m = {$urandom, $urandom, $urandom, $urandom};
            run(n, m, wide, sg, act, "R1 mixed");
        end
    endtask

    initial begin
        rst = 1; in_valid = 0; lane_wide = 0; is_signed = 0; act_bytes = 16;
        opnd_n = '0; opnd_m = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(out_valid == 1'b0, "R10 initial valid", 128'(out_valid), 128'h0);
        check(result == '0, "R10 initial result", result, '0);
        t_byte_left();
        t_byte_right();
        t_half();
        t_tail();
        t_hold();
        t_mixed();
        run({16{8'hFF}}, '0, 0, 0, 16, "R10 preload");
        t_reset();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule